// File: doc/BRIEF.md
# Shadowed Four-Channel Pulse-Width Modulator

This block drives four independent pulse-width modulated outputs. Software programs each channel through a small word-addressed register window. Each channel has a period value, a high-time (duty) value and a control word. The control word chooses a power-of-two step length, counted in pulses of a free-running 1 MHz enable input, and can invert the output.

Register writes land in a shadow copy first. A write to the period register arms the channel. The shadow set (period, duty and control together) moves into the running set only when the current period has finished. The waveform therefore changes between periods and never part-way through one. A channel whose running period is zero is idle. Its output is held low whatever the polarity setting, and arming it with a nonzero period starts a new period at once. Writing a zero period lets the running period finish and then parks the channel in that low, idle state.

The bus is a plain write strobe with an address and write data. Read data is a combinational function of the address. No flow control is needed, because every access completes in the cycle it is presented.

Top module: `pwm_shadow_ctrl`

## Requirements
- R1: While reset is asserted and immediately after it, every output is low and every register reads as zero.
- R2: Registers sit at byte address 0x400+4·c (period), 0x420+4·c (duty) and 0x440+4·c (control) for channel c = 0..3. Period and duty keep write-data bits [15:0]. Control keeps bits [1:0] (step divider) and bit 5 (invert). A read returns the stored shadow bits in those positions and zero in all other positions.
- R3: With the enable input high every cycle, one counter step lasts 2^div cycles. A period then lasts period·2^div cycles, and in normal polarity the output is high for min(duty, period)·2^div of those cycles (duty at or above period gives a constant high).
- R4: With the invert bit set, a running channel drives the complement of its normal-polarity waveform.
- R5: Duty or control writes that are not followed by a period write never change the output.
- R6: After a period write to a running channel, the rest of the current period keeps the old waveform, and the next period uses all the new shadow values.
- R7: A zero period write lets the current period run to its end. From then on the output stays low, even when the invert bit is set.
- R8: An idle channel armed with a nonzero period starts counting from zero on the clock edge after the edge that captures the write.
- R9: Channels are independent: each output depends only on its own registers.
- R10: The step counter advances only in cycles where the enable input is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_i | input | 1 | Free-running 1 MHz enable pulse |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | 12 | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (shadow values) |
| pwm_o | output | 4 | Per-channel modulated outputs |

## Verification
The hardest case to reach is a period write that lands in the middle of a running period. Here the bench has to see the old waveform finish and the new one begin exactly at the boundary. The stimulus locks onto a rising output edge, which fixes the counter phase. It then forks a sampler that counts high cycles period by period, alongside a writer that issues duty and period writes a few cycles later. A zero-period stop with inverted polarity is approached the same way. A sweep over divider, polarity, period and every duty up to one beyond the period compares high-cycle and rising-edge counts over two-period windows against arithmetic expectations.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned NUM_CH       = 4;
  localparam int unsigned ADDR_W       = 12;
  localparam int unsigned DATA_W       = 32;
  localparam int unsigned CNT_W        = 16;
  localparam int unsigned DIV_W        = 2;
  localparam int unsigned CTRL_INV_BIT = 5;
  localparam logic [11:0] OFS_PER      = 12'h400;
  localparam logic [11:0] OFS_DUTY     = 12'h420;
  localparam logic [11:0] OFS_CTRL     = 12'h440;
endpackage

// File: rtl/pwm_regdec.sv
module pwm_regdec #(
  parameter int unsigned NUM_CH = pwm_pkg::NUM_CH,
  parameter int unsigned ADDR_W = pwm_pkg::ADDR_W,
  parameter int unsigned DATA_W = pwm_pkg::DATA_W,
  parameter int unsigned CNT_W  = pwm_pkg::CNT_W,
  parameter int unsigned DIV_W  = pwm_pkg::DIV_W
) (
  input  logic                          bus_wr_i,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  sh_per_i,
  input  logic [NUM_CH-1:0][CNT_W-1:0]  sh_duty_i,
  input  logic [NUM_CH-1:0][DIV_W-1:0]  sh_div_i,
  input  logic [NUM_CH-1:0]             sh_inv_i,
  output logic [NUM_CH-1:0]             wr_per_o,
  output logic [NUM_CH-1:0]             wr_duty_o,
  output logic [NUM_CH-1:0]             wr_ctrl_o,
  output logic [DATA_W-1:0]             rdata_o
);
  localparam logic [ADDR_W-1:0] A_PER  = ADDR_W'(pwm_pkg::OFS_PER);
  localparam logic [ADDR_W-1:0] A_DUTY = ADDR_W'(pwm_pkg::OFS_DUTY);
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(pwm_pkg::OFS_CTRL);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] STRIDE = ADDR_W'(4 * c);
    assign wr_per_o[c]  = bus_wr_i && (bus_addr_i == A_PER  + STRIDE);
    assign wr_duty_o[c] = bus_wr_i && (bus_addr_i == A_DUTY + STRIDE);
    assign wr_ctrl_o[c] = bus_wr_i && (bus_addr_i == A_CTRL + STRIDE);
  end

  always_comb begin
    rdata_o = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (bus_addr_i == A_PER + ADDR_W'(4 * c))
        rdata_o[CNT_W-1:0] = sh_per_i[c];
      if (bus_addr_i == A_DUTY + ADDR_W'(4 * c))
        rdata_o[CNT_W-1:0] = sh_duty_i[c];
      if (bus_addr_i == A_CTRL + ADDR_W'(4 * c)) begin
        rdata_o[DIV_W-1:0]                 = sh_div_i[c];
        rdata_o[pwm_pkg::CTRL_INV_BIT]     = sh_inv_i[c];
      end
    end
  end
endmodule

// File: rtl/pwm_chan.sv
module pwm_chan #(
  parameter int unsigned CNT_W = pwm_pkg::CNT_W,
  parameter int unsigned DIV_W = pwm_pkg::DIV_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             wr_per_i,
  input  logic             wr_duty_i,
  input  logic             wr_ctrl_i,
  input  logic [CNT_W-1:0] wr_val_i,
  input  logic [DIV_W-1:0] wr_div_i,
  input  logic             wr_inv_i,
  output logic [CNT_W-1:0] sh_per_o,
  output logic [CNT_W-1:0] sh_duty_o,
  output logic [DIV_W-1:0] sh_div_o,
  output logic             sh_inv_o,
  output logic             pwm_o
);
  // widest step is 2^(2^DIV_W - 1) ticks, so the prescaler needs that many bits
  localparam int unsigned PRE_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] act_per_q, act_duty_q, cnt_q;
  logic [DIV_W-1:0] act_div_q;
  logic             act_inv_q, pend_q;
  logic [PRE_W-1:0] pre_q, pre_lim;
  logic             running, step, last, commit;

  assign running = (act_per_q != '0);
  assign pre_lim = ~({PRE_W{1'b1}} << act_div_q);
  assign step    = running && tick_i && (pre_q == pre_lim);
  assign last    = (cnt_q == act_per_q - CNT_W'(1));
  assign commit  = pend_q && (!running || (step && last));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_per_o   <= '0;
      sh_duty_o  <= '0;
      sh_div_o   <= '0;
      sh_inv_o   <= 1'b0;
      act_per_q  <= '0;
      act_duty_q <= '0;
      act_div_q  <= '0;
      act_inv_q  <= 1'b0;
      pend_q     <= 1'b0;
      cnt_q      <= '0;
      pre_q      <= '0;
    end else begin
      if (wr_per_i)  sh_per_o  <= wr_val_i;
      if (wr_duty_i) sh_duty_o <= wr_val_i;
      if (wr_ctrl_i) begin
        sh_div_o <= wr_div_i;
        sh_inv_o <= wr_inv_i;
      end
      pend_q <= wr_per_i || (pend_q && !commit);
      if (commit) begin
        act_per_q  <= sh_per_o;
        act_duty_q <= sh_duty_o;
        act_div_q  <= sh_div_o;
        act_inv_q  <= sh_inv_o;
        cnt_q      <= '0;
        pre_q      <= '0;
      end else if (step) begin
        pre_q <= '0;
        cnt_q <= last ? '0 : cnt_q + CNT_W'(1);
      end else if (running && tick_i) begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign pwm_o = running && ((cnt_q < act_duty_q) ^ act_inv_q);

  p_hold_unless_pending_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q |=> ($stable(act_per_q) && $stable(act_duty_q)
                 && $stable(act_div_q) && $stable(act_inv_q)));
  p_pend_on_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_per_i |=> pend_q);
  p_cnt_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt_q < act_per_q));
  p_pre_in_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (pre_q <= pre_lim));
  p_no_step_without_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick_i && !pend_q) |=> $stable(cnt_q));
endmodule

// File: rtl/pwm_shadow_ctrl.sv
module pwm_shadow_ctrl #(
  parameter int unsigned NUM_CH = pwm_pkg::NUM_CH,
  parameter int unsigned ADDR_W = pwm_pkg::ADDR_W,
  parameter int unsigned DATA_W = pwm_pkg::DATA_W,
  parameter int unsigned CNT_W  = pwm_pkg::CNT_W,
  parameter int unsigned DIV_W  = pwm_pkg::DIV_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic              bus_wr_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [DATA_W-1:0] bus_wdata_i,
  output logic [DATA_W-1:0] bus_rdata_o,
  output logic [NUM_CH-1:0] pwm_o
);
  logic [NUM_CH-1:0][CNT_W-1:0] sh_per, sh_duty;
  logic [NUM_CH-1:0][DIV_W-1:0] sh_div;
  logic [NUM_CH-1:0]            sh_inv, wr_per, wr_duty, wr_ctrl;
  logic                         unused_wdata;

  assign unused_wdata = ^bus_wdata_i[DATA_W-1:CNT_W];

  pwm_regdec #(
    .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) regdec_i (
    .bus_wr_i   (bus_wr_i),
    .bus_addr_i (bus_addr_i),
    .sh_per_i   (sh_per),
    .sh_duty_i  (sh_duty),
    .sh_div_i   (sh_div),
    .sh_inv_i   (sh_inv),
    .wr_per_o   (wr_per),
    .wr_duty_o  (wr_duty),
    .wr_ctrl_o  (wr_ctrl),
    .rdata_o    (bus_rdata_o)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    pwm_chan #(.CNT_W(CNT_W), .DIV_W(DIV_W)) chan_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_i),
      .wr_per_i  (wr_per[c]),
      .wr_duty_i (wr_duty[c]),
      .wr_ctrl_i (wr_ctrl[c]),
      .wr_val_i  (bus_wdata_i[CNT_W-1:0]),
      .wr_div_i  (bus_wdata_i[DIV_W-1:0]),
      .wr_inv_i  (bus_wdata_i[pwm_pkg::CTRL_INV_BIT]),
      .sh_per_o  (sh_per[c]),
      .sh_duty_o (sh_duty[c]),
      .sh_div_o  (sh_div[c]),
      .sh_inv_o  (sh_inv[c]),
      .pwm_o     (pwm_o[c])
    );
  end

  p_one_strobe_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wr_per, wr_duty, wr_ctrl}));
endmodule

// File: tb/pwm_shadow_ctrl_tb_top.sv
module pwm_shadow_ctrl_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b1;
  logic        bus_wr_i = 1'b0;
  logic [11:0] bus_addr_i = '0;
  logic [31:0] bus_wdata_i = '0;
  logic [31:0] bus_rdata_o;
  logic [3:0]  pwm_o;

  int n_cmp = 0;
  int n_err = 0;
  int tick_every = 1;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwm_shadow_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .bus_wr_i(bus_wr_i),
    .bus_addr_i(bus_addr_i), .bus_wdata_i(bus_wdata_i),
    .bus_rdata_o(bus_rdata_o), .pwm_o(pwm_o)
  );

  initial begin
    int k = 0;
    forever begin
      @(negedge clk);
      k = (k + 1) % tick_every;
      tick_i = (k == 0);
    end
  end

  function automatic logic [11:0] a_per(int c);  return 12'(32'h400 + 4 * c); endfunction
  function automatic logic [11:0] a_duty(int c); return 12'(32'h420 + 4 * c); endfunction
  function automatic logic [11:0] a_ctrl(int c); return 12'(32'h440 + 4 * c); endfunction

  task automatic check(string req, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    bus_wr_i = 1'b1; bus_addr_i = a; bus_wdata_i = d;
    @(negedge clk);
    bus_wr_i = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output int d);
    bus_addr_i = a;
    #1;
    d = int'(bus_rdata_o);
  endtask

  task automatic config_ch(int c, int div, int inv, int per, int duty);
    wr(a_ctrl(c), 32'(div | (inv << 5)));
    wr(a_duty(c), 32'(duty));
    wr(a_per(c), 32'(per));
  endtask

  task automatic measure(int c, int n, output int hi, output int rises);
    logic prev;
    prev = pwm_o[c]; hi = 0; rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      hi += int'(pwm_o[c]);
      if (!prev && pwm_o[c]) rises++;
      prev = pwm_o[c];
    end
  endtask

  task automatic wait_rise(int c);
    logic prev;
    prev = pwm_o[c];
    forever begin
      @(negedge clk);
      if (!prev && pwm_o[c]) break;
      prev = pwm_o[c];
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_cmp++; n_err++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    int v, hi, ri, n;
    int pers[4] = '{1, 2, 3, 5};
    // R1: reset state
    repeat (4) @(negedge clk);
    check("R1 outputs in reset", int'(pwm_o), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 outputs after reset", int'(pwm_o), 0);
    rd(a_ctrl(1), v); check("R1 ctrl reads zero", v, 0);
    rd(a_per(3), v);  check("R1 period reads zero", v, 0);

    // R2: readback of shadow fields
    wr(a_duty(3), 32'hFFFF_0055); rd(a_duty(3), v); check("R2 duty readback", v, 32'h55);
    wr(a_ctrl(3), 32'hFFFF_FFFF); rd(a_ctrl(3), v); check("R2 ctrl readback", v, 32'h23);
    wr(a_per(3), 32'h0001_0000);  rd(a_per(3), v);  check("R2 period low bits", v, 0);
    rd(a_duty(2), v); check("R2 neighbour untouched", v, 0);
    repeat (4) @(negedge clk);
    check("R7 zero period keeps idle low", int'(pwm_o[3]), 0);

    // R3/R4: sweep divider, polarity, period and duty
    n = 0;
    for (int dv = 0; dv < 4; dv++)
      for (int iv = 0; iv < 2; iv++)
        foreach (pers[p])
          for (int du = 0; du <= pers[p] + 1; du++) begin
            int c, t, h;
            c = n % 4; n++;
            config_ch(c, dv, iv, pers[p], du);
            repeat (100) @(negedge clk);
            t = pers[p] << dv;
            h = ((du < pers[p]) ? du : pers[p]) << dv;
            measure(c, 2 * t, hi, ri);
            if (iv == 0) check("R3 high cycles", hi, 2 * h);
            else         check("R4 inverted high cycles", hi, 2 * (t - h));
            if (du > 0 && du < pers[p]) check("R3 periods per window", ri, 2);
          end

    // R5: duty and control writes without period write have no effect
    config_ch(0, 0, 0, 4, 1);
    repeat (40) @(negedge clk);
    wr(a_duty(0), 3);
    wr(a_ctrl(0), 32'h20);
    repeat (40) @(negedge clk);
    measure(0, 8, hi, ri); check("R5 pending duty ignored", hi, 2);
    wr(a_per(0), 4);
    repeat (40) @(negedge clk);
    measure(0, 8, hi, ri); check("R5 applied after period write", hi, 2);

    // R6: mid-period update switches exactly at the boundary
    config_ch(2, 0, 0, 10, 2);
    repeat (60) @(negedge clk);
    wait_rise(2);
    begin
      int h1, h2;
      h1 = int'(pwm_o[2]); h2 = 0;
      fork
        begin
          for (int i = 1; i < 20; i++) begin
            @(negedge clk);
            if (i < 10) h1 += int'(pwm_o[2]); else h2 += int'(pwm_o[2]);
          end
        end
        begin
          repeat (2) @(negedge clk);
          wr(a_duty(2), 7);
          wr(a_per(2), 10);
        end
      join
      check("R6 current period keeps old duty", h1, 2);
      check("R6 next period uses new duty", h2, 7);
    end

    // R7: stop with inverted polarity finishes period then holds low
    config_ch(1, 0, 1, 6, 3);
    repeat (60) @(negedge clk);
    wait_rise(1);
    begin
      int h1, h2;
      h1 = 1; h2 = 0;
      fork
        begin
          for (int i = 1; i < 23; i++) begin
            @(negedge clk);
            if (i < 3) h1 += int'(pwm_o[1]); else h2 += int'(pwm_o[1]);
          end
        end
        wr(a_per(1), 0);
      join
      check("R7 running period completes", h1, 3);
      check("R7 low after stop", h2, 0);
    end

    // R8: idle channel starts on edge after the write edge
    wr(a_ctrl(1), 0);
    wr(a_duty(1), 2);
    check("R8 idle unaffected by duty write", int'(pwm_o[1]), 0);
    wr(a_per(1), 4);
    check("R8 not started at write edge", int'(pwm_o[1]), 0);
    @(negedge clk);
    check("R8 first count high", int'(pwm_o[1]), 1);
    hi = int'(pwm_o[1]);
    for (int i = 0; i < 3; i++) begin @(negedge clk); hi += int'(pwm_o[1]); end
    check("R8 first period high time", hi, 2);

    // R9: independent channels
    for (int c = 0; c < 4; c++) config_ch(c, 0, 0, 8, c + 1);
    repeat (60) @(negedge clk);
    for (int c = 0; c < 4; c++) begin
      measure(c, 16, hi, ri);
      check("R9 per-channel high cycles", hi, 2 * (c + 1));
    end

    // R10: enable every third cycle, divider 2
    tick_every = 3;
    config_ch(3, 1, 0, 4, 1);
    repeat (200) @(negedge clk);
    measure(3, 48, hi, ri);
    check("R10 gated high cycles", hi, 12);
    check("R10 gated periods", ri, 2);
    tick_every = 1;

    finish_run();
  end
endmodule